// File: doc/BRIEF.md
# Adaptive Beamwidth Controller

This block sets the pruning beamwidth that a speech search engine applies in each frame. When a frame opens, the controller looks at how many tokens are active and moves the beam by a fixed step. A heavy token load narrows the beam, which cuts the work. A light load widens it again, but only if it was narrowed before, and never past its starting width. A count that lies between the two thresholds leaves the beam alone. The effect is a hysteresis band that remembers earlier tightening.

The search control logic drives the inputs. It pulses `utt_start` at the start of each utterance, which restores the initial width. It pulses `frame_stb` once per frame, before token passing begins, together with that frame's active-token count. The two thresholds are live inputs, so the owner can retune them between frames; for example, it can switch from 2300/1900 to the tighter 1700/1250. The initial width, the minimum width and the step are elaboration parameters. The new width is registered and stays constant until the next frame strobe.

Top module: `beam_adapt_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `beam_width` equals INIT_BEAM (default 170).
- R2: On a frame strobe with `token_cnt` strictly greater than `hi_thresh`, `beam_width` falls by STEP (default 10).
- R3: Tightening never takes `beam_width` below MIN_BEAM (default 125). A step that would go below the floor lands on MIN_BEAM.
- R4: On a frame strobe with `token_cnt` strictly less than `lo_thresh` and `beam_width` below INIT_BEAM, `beam_width` rises by STEP. It is capped at INIT_BEAM.
- R5: On a frame strobe with `token_cnt` below `lo_thresh` while `beam_width` already equals INIT_BEAM, `beam_width` is unchanged.
- R6: On a frame strobe with `lo_thresh <= token_cnt <= hi_thresh` (both ends included), `beam_width` is unchanged.
- R7: In a cycle without `frame_stb` or `utt_start`, `beam_width` keeps its value whatever `token_cnt` and the thresholds do.
- R8: `utt_start` reloads INIT_BEAM and takes priority over a frame strobe in the same cycle.
- R9: The thresholds are taken from `hi_thresh`/`lo_thresh` at each strobe. After they are reprogrammed, the same count can give a different decision.
- R10: If the thresholds are set inverted, so that a count lies both above `hi_thresh` and below `lo_thresh`, tightening wins.
- R11: The new width appears at the clock edge that samples the strobe. Before that edge, `beam_width` still shows the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| utt_start | input | 1 | Start of utterance: reload the initial width |
| frame_stb | input | 1 | One-cycle pulse at the start of each frame |
| token_cnt | input | CNT_W (16) | Active-token count for the frame |
| hi_thresh | input | CNT_W (16) | Tightening threshold |
| lo_thresh | input | CNT_W (16) | Relaxing threshold |
| beam_width | output | BEAM_W (8) | Beamwidth in force for the current frame |

## Verification
Every result is due at the first rising edge after the strobe or reload is applied, with exactly one register on the path. The bench therefore changes the inputs on the falling edge, lets one rising edge pass, and samples 5 ns after that edge. One directed test also samples before the edge, to confirm that the old width is still shown at that point. The reset result is sampled in the same way, one edge after `rst_n` is driven.

// File: rtl/beam_pkg.sv
package beam_pkg;
  // Load band that the active-token count falls in for one frame
  typedef enum logic [1:0] {
    ZONE_MID  = 2'd0,
    ZONE_HIGH = 2'd1,
    ZONE_LOW  = 2'd2
  } zone_e;
endpackage

// File: rtl/beam_zone_cmp.sv
module beam_zone_cmp
  import beam_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] hi_thr,
  input  logic [CNT_W-1:0] lo_thr,
  output zone_e            zone
);
  logic above_hi;
  logic below_lo;

  assign above_hi = (count > hi_thr);
  assign below_lo = (count < lo_thr);

  // The heavy-load side has priority when the thresholds are inverted
  always_comb begin
    if (above_hi)      zone = ZONE_HIGH;
    else if (below_lo) zone = ZONE_LOW;
    else               zone = ZONE_MID;
  end
endmodule

// File: rtl/beam_step_calc.sv
module beam_step_calc
  import beam_pkg::*;
#(
  parameter int BEAM_W    = 8,
  parameter int INIT_BEAM = 170,
  parameter int MIN_BEAM  = 125,
  parameter int STEP      = 10
) (
  input  logic [BEAM_W-1:0] cur_beam,
  input  zone_e             zone,
  output logic [BEAM_W-1:0] next_beam,
  output logic              tighten_ev,
  output logic              relax_ev
);
  localparam int SUM_W = BEAM_W + 1;
  localparam logic [SUM_W-1:0] INIT_X = SUM_W'(INIT_BEAM);
  localparam logic [SUM_W-1:0] MIN_X  = SUM_W'(MIN_BEAM);
  localparam logic [SUM_W-1:0] STEP_X = SUM_W'(STEP);

  // Narrow by one step, landing on the floor if the step would cross it
  function automatic logic [BEAM_W-1:0] narrow(input logic [BEAM_W-1:0] b);
    logic [SUM_W-1:0] bx;
    bx = {1'b0, b};
    if (bx < MIN_X + STEP_X) return BEAM_W'(MIN_X);
    else                     return BEAM_W'(bx - STEP_X);
  endfunction

  // Widen by one step, landing on the initial width if the step would pass it
  function automatic logic [BEAM_W-1:0] widen(input logic [BEAM_W-1:0] b);
    logic [SUM_W-1:0] sum;
    sum = {1'b0, b} + STEP_X;
    if (sum > INIT_X) return BEAM_W'(INIT_X);
    else              return BEAM_W'(sum);
  endfunction

  logic was_tightened;
  assign was_tightened = ({1'b0, cur_beam} < INIT_X);
  assign tighten_ev    = (zone == ZONE_HIGH);
  assign relax_ev      = (zone == ZONE_LOW) && was_tightened;

  always_comb begin
    if (tighten_ev)    next_beam = narrow(cur_beam);
    else if (relax_ev) next_beam = widen(cur_beam);
    else               next_beam = cur_beam;
  end
endmodule

// File: rtl/beam_adapt_ctrl.sv
module beam_adapt_ctrl
  import beam_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int BEAM_W    = 8,
  parameter int INIT_BEAM = 170,
  parameter int MIN_BEAM  = 125,
  parameter int STEP      = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              utt_start,
  input  logic              frame_stb,
  input  logic [CNT_W-1:0]  token_cnt,
  input  logic [CNT_W-1:0]  hi_thresh,
  input  logic [CNT_W-1:0]  lo_thresh,
  output logic [BEAM_W-1:0] beam_width
);
  localparam logic [BEAM_W-1:0] INIT_V = BEAM_W'(INIT_BEAM);
  localparam logic [BEAM_W-1:0] MIN_V  = BEAM_W'(MIN_BEAM);

  zone_e             zone;
  logic [BEAM_W-1:0] beam_q;
  logic [BEAM_W-1:0] beam_nx;
  logic              tighten_ev;
  logic              relax_ev;
  logic              frame_go;   // strobe that is not overridden by a reload

  assign frame_go = frame_stb && !utt_start;

  beam_zone_cmp #(.CNT_W(CNT_W)) u_zone (
    .count  (token_cnt),
    .hi_thr (hi_thresh),
    .lo_thr (lo_thresh),
    .zone   (zone)
  );

  beam_step_calc #(
    .BEAM_W    (BEAM_W),
    .INIT_BEAM (INIT_BEAM),
    .MIN_BEAM  (MIN_BEAM),
    .STEP      (STEP)
  ) u_step (
    .cur_beam   (beam_q),
    .zone       (zone),
    .next_beam  (beam_nx),
    .tighten_ev (tighten_ev),
    .relax_ev   (relax_ev)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)         beam_q <= INIT_V;
    else if (utt_start) beam_q <= INIT_V;
    else if (frame_stb) beam_q <= beam_nx;
  end

  assign beam_width = beam_q;

  AST_BEAM_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (beam_q >= MIN_V) && (beam_q <= INIT_V)); // R3
  AST_RESET_INIT: assert property (@(posedge clk)
    !rst_n |=> beam_q == INIT_V); // R1
  AST_TIGHTEN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    frame_go && (zone == ZONE_HIGH) |=>
      (int'(beam_q) == int'($past(beam_q)) - STEP) || (beam_q == MIN_V)); // R2
  AST_RELAX_UP: assert property (@(posedge clk) disable iff (!rst_n)
    frame_go && (zone == ZONE_LOW) && (beam_q < INIT_V) |=> beam_q > $past(beam_q)); // R4
  AST_LOW_AT_INIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    frame_go && (zone == ZONE_LOW) && (beam_q == INIT_V) |=> beam_q == INIT_V); // R5
  AST_MID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    frame_go && (zone == ZONE_MID) |=> $stable(beam_q)); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_stb && !utt_start |=> $stable(beam_q)); // R7
  AST_UTT_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    utt_start |=> beam_q == INIT_V); // R8
  AST_INVERTED_TIGHTENS: assert property (@(posedge clk) disable iff (!rst_n)
    frame_go && (token_cnt > hi_thresh) && (token_cnt < lo_thresh) |-> tighten_ev && !relax_ev); // R10
endmodule

// File: tb/beam_adapt_ctrl_bench.sv
module beam_adapt_ctrl_bench;
  localparam int CNT_W = 16;
  localparam int BEAM_W = 8;
  localparam int INIT_B = 170;
  localparam int MIN_B = 125;
  localparam int STEP_B = 10;

  typedef struct packed {
    logic        utt;
    logic        stb;
    logic [15:0] cnt;
    logic [15:0] hi;
    logic [15:0] lo;
    logic [7:0]  expv;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b1, 16'd2000, 16'd2300, 16'd1900, 8'd170, 8'd6},  // R6 mid band
    '{1'b0, 1'b1, 16'd1000, 16'd2300, 16'd1900, 8'd170, 8'd5},  // R5 low at init
    '{1'b0, 1'b1, 16'd2301, 16'd2300, 16'd1900, 8'd160, 8'd2},  // R2 just above
    '{1'b0, 1'b0, 16'd3000, 16'd2300, 16'd1900, 8'd160, 8'd7},  // R7 no strobe
    '{1'b0, 1'b1, 16'd2300, 16'd2300, 16'd1900, 8'd160, 8'd6},  // R6 equal hi
    '{1'b0, 1'b1, 16'd1900, 16'd2300, 16'd1900, 8'd160, 8'd6},  // R6 equal lo
    '{1'b0, 1'b1, 16'd1899, 16'd2300, 16'd1900, 8'd170, 8'd4},  // R4 relax
    '{1'b0, 1'b1, 16'd2500, 16'd2300, 16'd1900, 8'd160, 8'd2},  // R2
    '{1'b0, 1'b1, 16'd2500, 16'd2300, 16'd1900, 8'd150, 8'd2},  // R2
    '{1'b0, 1'b1, 16'd2500, 16'd2300, 16'd1900, 8'd140, 8'd2},  // R2
    '{1'b0, 1'b1, 16'd2500, 16'd2300, 16'd1900, 8'd130, 8'd2},  // R2
    '{1'b0, 1'b1, 16'd2500, 16'd2300, 16'd1900, 8'd125, 8'd3},  // R3 floor
    '{1'b0, 1'b1, 16'd9000, 16'd2300, 16'd1900, 8'd125, 8'd3},  // R3 stays
    '{1'b0, 1'b1, 16'd500,  16'd2300, 16'd1900, 8'd135, 8'd4},  // R4
    '{1'b0, 1'b0, 16'd500,  16'd2300, 16'd1900, 8'd135, 8'd7},  // R7
    '{1'b0, 1'b1, 16'd1800, 16'd1700, 16'd1250, 8'd125, 8'd9},  // R9 tighter hi
    '{1'b0, 1'b1, 16'd1500, 16'd1700, 16'd1250, 8'd125, 8'd9},  // R9 now mid
    '{1'b0, 1'b1, 16'd1200, 16'd1700, 16'd1250, 8'd135, 8'd9},  // R9 low
    '{1'b0, 1'b1, 16'd0,    16'd2300, 16'd1900, 8'd145, 8'd4},  // R4
    '{1'b0, 1'b1, 16'd0,    16'd2300, 16'd1900, 8'd155, 8'd4},  // R4
    '{1'b0, 1'b1, 16'd0,    16'd2300, 16'd1900, 8'd165, 8'd4},  // R4
    '{1'b0, 1'b1, 16'd0,    16'd2300, 16'd1900, 8'd170, 8'd4},  // R4 cap
    '{1'b0, 1'b1, 16'd1000, 16'd500,  16'd2000, 8'd160, 8'd10}, // R10 inverted
    '{1'b1, 1'b1, 16'd3000, 16'd2300, 16'd1900, 8'd170, 8'd8},  // R8 priority
    '{1'b0, 1'b0, 16'd3000, 16'd2300, 16'd1900, 8'd170, 8'd7}   // R7
  };

  logic              clk = 1'b0;
  logic              rst_n;
  logic              utt_start;
  logic              frame_stb;
  logic [CNT_W-1:0]  token_cnt;
  logic [CNT_W-1:0]  hi_thresh;
  logic [CNT_W-1:0]  lo_thresh;
  logic [BEAM_W-1:0] beam_width;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  beam_adapt_ctrl #(
    .CNT_W(CNT_W), .BEAM_W(BEAM_W), .INIT_BEAM(INIT_B),
    .MIN_BEAM(MIN_B), .STEP(STEP_B)
  ) u_beam_adapt_ctrl (
    .clk(clk), .rst_n(rst_n), .utt_start(utt_start), .frame_stb(frame_stb),
    .token_cnt(token_cnt), .hi_thresh(hi_thresh), .lo_thresh(lo_thresh),
    .beam_width(beam_width)
  );

  task automatic check(input int expv, input int req, input string what);
    checks++;
    if (int'(beam_width) != expv) begin
      errors++;
      $display("FAIL R%0d %s: beam_width=%0d expected %0d", req, what, beam_width, expv);
    end
  endtask

  // Apply inputs on the falling edge, then sample 5 ns after the next rising edge
  task automatic apply(input logic u, input logic s, input int c, input int h, input int l);
    @(negedge clk);
    utt_start = u; frame_stb = s;
    token_cnt = CNT_W'(c); hi_thresh = CNT_W'(h); lo_thresh = CNT_W'(l);
    @(posedge clk);
    #5;
  endtask

  initial begin
    rst_n = 1'b0; utt_start = 1'b0; frame_stb = 1'b0;
    token_cnt = '0; hi_thresh = 16'd2300; lo_thresh = 16'd1900;
    repeat (2) @(posedge clk);
    #5;
    check(INIT_B, 1, "reset value");  // R1
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #5;
    check(INIT_B, 1, "first cycle after reset");  // R1

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].utt, VECS[i].stb, int'(VECS[i].cnt), int'(VECS[i].hi), int'(VECS[i].lo));
      check(int'(VECS[i].expv), int'(VECS[i].req), $sformatf("vector %0d", i));
    end

    // R11: the result is not visible before the sampling edge, and is visible after it
    @(negedge clk);
    utt_start = 1'b0; frame_stb = 1'b1; token_cnt = 16'd4000;
    hi_thresh = 16'd2300; lo_thresh = 16'd1900;
    #5;
    check(INIT_B, 11, "old width before edge");
    @(posedge clk);
    #5;
    check(INIT_B - STEP_B, 11, "new width after edge");
    apply(1'b0, 1'b0, 0, 2300, 1900);
    check(INIT_B - STEP_B, 11, "held after strobe drops");

    // R1: reset in the middle of a run restores the initial width
    @(negedge clk);
    rst_n = 1'b0; frame_stb = 1'b1; token_cnt = 16'd4000;
    @(posedge clk);
    #5;
    check(INIT_B, 1, "mid-run reset");
    @(negedge clk);
    rst_n = 1'b1; frame_stb = 1'b0;

    // R8: a lone reload with no strobe after tightening
    apply(1'b0, 1'b1, 4000, 2300, 1900);
    check(INIT_B - STEP_B, 2, "tighten before reload");
    apply(1'b1, 1'b0, 4000, 2300, 1900);
    check(INIT_B, 8, "lone reload");
    apply(1'b0, 1'b0, 0, 2300, 1900);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule